// File: doc/BRIEF.md
# PCI Initiator Termination Controller

This block is the control core of the initiator side of a bridge that replays transactions on a PCI target bus. Once a transaction has been accepted, the block asserts FRAME#, then IRDY#, for the data phases. It watches the target's DEVSEL#, TRDY# and STOP# lines and decides which data phase is the final one. That decision depends on the transaction kind, on indications from the data path (the write buffer holds its last DWORD, or a prefetch boundary has been reached) and on the master latency timer together with the bus grant.

When the transaction closes, the block gives one `done` pulse carrying an encoded outcome. The outcome is one of: completed, master abort, retry, disconnect, target abort, or cut by the latency timer. A posted write that the latency timer cut short also raises `resume_req`. The surrounding logic then issues a follow-up transaction starting at `cur_addr`, which already points at the first DWORD not yet delivered. A prefetch read cut the same way is dropped and is not re-issued.

Top module: `pci_init_term_ctl`

## Requirements
- R1: After reset, `frame_n` and `irdy_n` are high, `done` and `resume_req` are low, and `status` is 0 (no outcome).
- R2: A delayed write (`kind`=0) or a non-prefetchable read (`kind`=1) makes its first data phase the final one and moves exactly one DWORD. It closes with `status`=1 (completed).
- R3: A posted write (`kind`=3) or a memory-write-and-invalidate (`kind`=4) keeps bursting until `wbuf_last` is high at the edge that opens a data phase. That phase is then the final one, and the outcome is `status`=1.
- R4: A prefetchable read (`kind`=2) makes the data phase final when `pf_bound` is high at the edge that opens it, and closes with `status`=1.
- R5: If `devsel_n` is not sampled low on any of the first five rising edges after the edge that asserted `frame_n`, the transaction closes with `status`=2 (master abort). A first low sample on the fifth edge still counts as a response.
- R6: On a master abort, `frame_n` and `irdy_n` are both high from the clock after detection onward. FRAME# and IRDY# are released together when the abort hits mid-burst. IRDY# alone is released when FRAME# was already high.
- R7: The latency timer is loaded from `lt_init` on the edge that asserts FRAME#, and counts down by one per clock until it reaches zero. For `kind` 2 or 3, an edge that opens a data phase while the timer is zero and `gnt_n` is high makes that phase final. The outcome is then `status`=6 (latency cut), unless the kind's own end condition also held at that edge, in which case it is `status`=1.
- R8: A memory-write-and-invalidate (`kind`=4) is never ended by the latency timer and never reports `status`=6.
- R9: When a posted write closes with `status`=6, `resume_req` pulses together with `done`. When a prefetch read closes with `status`=6, `resume_req` stays low.
- R10: STOP# low while the target has claimed the cycle ends the transaction, and the outcome depends on the other target lines. It is `status`=3 (retry) when no DWORD moved. It is `status`=4 (disconnect) when data moved, or moves on that same edge. It is `status`=5 (target abort) when DEVSEL# is high at that edge after having been seen low earlier.
- R11: `cur_addr` is loaded with `start_addr` at acceptance. It advances by 4 on every edge that completes a data phase, meaning IRDY#, TRDY# and DEVSEL# are all low. At `done` it holds the address of the next undelivered DWORD.
- R12: The final data phase has `frame_n` high and `irdy_n` low. Both are high on the clock after the last transfer, and `done` is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new transaction (sampled while idle) |
| kind | input | 3 | Transaction kind: 0 delayed write, 1 non-prefetch read, 2 prefetch read, 3 posted write, 4 memory write and invalidate |
| start_addr | input | ADDR_W | First DWORD byte address |
| lt_init | input | LT_W | Latency timer load value |
| gnt_n | input | 1 | Bus grant, active low |
| devsel_n | input | 1 | Target claim, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| wbuf_last | input | 1 | The phase being opened carries the last buffered write DWORD |
| pf_bound | input | 1 | The phase being opened reaches the prefetch boundary |
| frame_n | output | 1 | FRAME#, registered |
| irdy_n | output | 1 | IRDY#, registered |
| done | output | 1 | One-clock outcome strobe |
| status | output | 3 | Outcome: 1 completed, 2 master abort, 3 retry, 4 disconnect, 5 target abort, 6 latency cut |
| resume_req | output | 1 | Posted write must be resumed from `cur_addr` |
| cur_addr | output | ADDR_W | Current DWORD address |

## Verification
The bench uses the defaults: a 32-bit address, an 8-bit latency timer and a DEVSEL# window of five clocks. With a small `lt_init` (0 to 2), timer expiry falls inside bursts of a few DWORDs. That makes the tie between the latency cut and the natural end, and the exemption for memory-write-and-invalidate, reachable in a handful of clocks. The five-clock window is driven at both sides of its edge: a claim delayed by four clocks is first seen on the fifth edge and must pass, while no claim at all must abort, both from a final phase and from mid-burst.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
  typedef enum logic [2:0] {
    K_DLYWR  = 3'd0,
    K_NPRD   = 3'd1,
    K_PFRD   = 3'd2,
    K_POSTWR = 3'd3,
    K_MWI    = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    ST_NONE   = 3'd0,
    ST_OK     = 3'd1,
    ST_MABORT = 3'd2,
    ST_RETRY  = 3'd3,
    ST_DISC   = 3'd4,
    ST_TABORT = 3'd5,
    ST_LTCUT  = 3'd6
  } stat_e;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_ADDR    = 3'd1,
    S_DATA    = 3'd2,
    S_LAST    = 3'd3,
    S_STOPREL = 3'd4,
    S_END     = 3'd5
  } fsm_e;
endpackage

// File: rtl/pit_dsel_watch.sv
`timescale 1ns/1ps
// Counts the edges on which the target has not yet claimed the cycle.
module pit_dsel_watch #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic devsel_n,
  output logic seen,
  output logic timeout
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (run) begin
      if (!devsel_n)
        seen <= 1'b1;
      else if (!seen && cnt != CW'(LIMIT - 1))
        cnt <= cnt + 1'b1;
    end
  end

  assign timeout = run && !seen && devsel_n && (cnt == CW'(LIMIT - 1));

  // R5: the controller leaves the active states right after an abort
  p_timeout_once_r5: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);
endmodule

// File: rtl/pit_lat_timer.sv
`timescale 1ns/1ps
// Master latency timer: loaded at FRAME# assertion, counts down to zero.
module pit_lat_timer #(
  parameter int LT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            run,
  input  logic [LT_W-1:0] init,
  output logic            zero
);
  logic [LT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= init;
    else if (run && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R7: between loads the timer never goes up
  p_lt_monotone_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> cnt <= $past(cnt));
endmodule

// File: rtl/pit_addr_ctr.sv
`timescale 1ns/1ps
// Current-DWORD byte address.
module pit_addr_ctr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] DW_BYTES = ADDR_W'(4);

  always_ff @(posedge clk) begin
    if (rst)
      addr <= '0;
    else if (load)
      addr <= ld_val;
    else if (step)
      addr <= addr + DW_BYTES;
  end

  // R11: no movement without a completed data phase
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(addr));
endmodule

// File: rtl/pci_init_term_ctl.sv
`timescale 1ns/1ps
module pci_init_term_ctl
  import pit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LT_W       = 8,
  parameter int DSEL_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        kind,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LT_W-1:0]   lt_init,
  input  logic              gnt_n,
  input  logic              devsel_n,
  input  logic              trdy_n,
  input  logic              stop_n,
  input  logic              wbuf_last,
  input  logic              pf_bound,
  output logic              frame_n,
  output logic              irdy_n,
  output logic              done,
  output logic [2:0]        status,
  output logic              resume_req,
  output logic [ADDR_W-1:0] cur_addr
);
  fsm_e  state;
  kind_e kind_q;
  stat_e status_q;
  logic  frame_n_q, irdy_n_q, done_q, resume_q;
  logic  lat_cut_q, any_xfer_q;

  logic accept, active, in_data;
  logic dsel_seen, mabort_hit, lt_zero;
  logic tgt_ok, xfer, tgt_stop;
  logic natural_last, lat_last, go_last;
  stat_e stop_code;

  assign accept  = (state == S_IDLE) && start;
  assign in_data = (state == S_DATA) || (state == S_LAST);
  assign active  = (state == S_ADDR) || in_data;

  pit_dsel_watch #(.LIMIT(DSEL_LIMIT)) u_dsel (
    .clk(clk), .rst(rst), .clr(accept), .run(active),
    .devsel_n(devsel_n), .seen(dsel_seen), .timeout(mabort_hit)
  );

  pit_lat_timer #(.LT_W(LT_W)) u_lt (
    .clk(clk), .rst(rst), .load(accept), .run(active),
    .init(lt_init), .zero(lt_zero)
  );

  pit_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load(accept), .ld_val(start_addr),
    .step(in_data && xfer), .addr(cur_addr)
  );

  // Target lines count only once the cycle has been claimed.
  assign tgt_ok   = dsel_seen || !devsel_n;
  assign xfer     = in_data && !devsel_n && !trdy_n;
  assign tgt_stop = in_data && tgt_ok && !stop_n;

  always_comb begin
    if (!devsel_n)
      stop_code = (xfer || any_xfer_q) ? ST_DISC : ST_RETRY;
    else
      stop_code = ST_TABORT;
  end

  // End condition of the phase being opened, by transaction kind.
  always_comb begin
    case (kind_q)
      K_DLYWR, K_NPRD: natural_last = 1'b1;
      K_PFRD:          natural_last = pf_bound;
      default:         natural_last = wbuf_last;
    endcase
  end

  assign lat_last = ((kind_q == K_PFRD) || (kind_q == K_POSTWR)) && lt_zero && gnt_n;
  assign go_last  = natural_last || lat_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      kind_q     <= K_DLYWR;
      status_q   <= ST_NONE;
      frame_n_q  <= 1'b1;
      irdy_n_q   <= 1'b1;
      done_q     <= 1'b0;
      resume_q   <= 1'b0;
      lat_cut_q  <= 1'b0;
      any_xfer_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      resume_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state      <= S_ADDR;
            kind_q     <= kind_e'(kind);
            status_q   <= ST_NONE;
            frame_n_q  <= 1'b0;
            irdy_n_q   <= 1'b1;
            lat_cut_q  <= 1'b0;
            any_xfer_q <= 1'b0;
          end
        end
        S_ADDR: begin
          if (mabort_hit) begin
            state     <= S_END;
            status_q  <= ST_MABORT;
            frame_n_q <= 1'b1;
            irdy_n_q  <= 1'b1;
            done_q    <= 1'b1;
          end else begin
            state     <= go_last ? S_LAST : S_DATA;
            frame_n_q <= go_last;
            irdy_n_q  <= 1'b0;
            lat_cut_q <= !natural_last && lat_last;
          end
        end
        S_DATA, S_LAST: begin
          if (xfer)
            any_xfer_q <= 1'b1;
          if (mabort_hit) begin
            state     <= S_END;
            status_q  <= ST_MABORT;
            frame_n_q <= 1'b1;
            irdy_n_q  <= 1'b1;
            done_q    <= 1'b1;
          end else if (tgt_stop) begin
            status_q <= stop_code;
            if (state == S_DATA) begin
              state     <= S_STOPREL;
              frame_n_q <= 1'b1;
              irdy_n_q  <= 1'b0;
            end else begin
              state     <= S_END;
              frame_n_q <= 1'b1;
              irdy_n_q  <= 1'b1;
              done_q    <= 1'b1;
            end
          end else if (xfer) begin
            if (state == S_LAST) begin
              state     <= S_END;
              status_q  <= lat_cut_q ? ST_LTCUT : ST_OK;
              resume_q  <= lat_cut_q && (kind_q == K_POSTWR);
              frame_n_q <= 1'b1;
              irdy_n_q  <= 1'b1;
              done_q    <= 1'b1;
            end else begin
              state     <= go_last ? S_LAST : S_DATA;
              frame_n_q <= go_last;
              irdy_n_q  <= 1'b0;
              lat_cut_q <= !natural_last && lat_last;
            end
          end
        end
        S_STOPREL: begin
          state     <= S_END;
          frame_n_q <= 1'b1;
          irdy_n_q  <= 1'b1;
          done_q    <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign frame_n    = frame_n_q;
  assign irdy_n     = irdy_n_q;
  assign done       = done_q;
  assign status     = status_q;
  assign resume_req = resume_q;

  // R6: abort releases both bus lines on the next clock
  p_abort_release_r6: assert property (@(posedge clk) disable iff (rst)
    mabort_hit |=> (frame_n && irdy_n));

  // R12: outcome strobe lasts one clock
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12: the transfer of the final phase returns the bus to idle
  p_last_close_r12: assert property (@(posedge clk) disable iff (rst)
    (frame_n && !irdy_n && !trdy_n && !devsel_n) |=> (frame_n && irdy_n));

  // R9: only a posted write ever asks to be resumed
  p_resume_post_r9: assert property (@(posedge clk) disable iff (rst)
    resume_req |-> (done && kind_q == K_POSTWR && status == 3'd6));

  // R8: memory write and invalidate is exempt from the latency cut
  p_mwi_exempt_r8: assert property (@(posedge clk) disable iff (rst)
    (done && kind_q == K_MWI) |-> (status != 3'd6));
endmodule

// File: tb/sim_pci_init_term_ctl.sv
`timescale 1ns/1ps
module sim_pci_init_term_ctl;
  localparam logic [2:0] K_DW = 3'd0, K_NR = 3'd1, K_PR = 3'd2, K_PW = 3'd3, K_MW = 3'd4;
  localparam logic [2:0] OK = 3'd1, MA = 3'd2, RT = 3'd3, DC = 3'd4, TA = 3'd5, LC = 3'd6;
  // target behaviours
  localparam int T_NORM = 0, T_RETRY = 1, T_DISCD = 2, T_DISCN = 3, T_TABT = 4, T_NONE = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] kind = 3'd0;
  logic [31:0] start_addr = 32'h0;
  logic [7:0] lt_init = 8'd0;
  logic gnt_n = 1'b0;
  logic devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
  logic wbuf_last, pf_bound;
  logic frame_n, irdy_n, done, resume_req;
  logic [2:0] status;
  logic [31:0] cur_addr;

  int total = 0;
  int bad = 0;

  typedef struct {
    string       tag;
    logic [2:0]  st;
    logic [31:0] ad;
    logic        rs;
  } exp_t;
  exp_t sb[$];

  int cfg_n = 1, cfg_b = 1, cfg_d = 0, cfg_mode = 0, cfg_k = 1;
  int ck = 0, xfers = 0, last_cycles = 0;
  logic stopped = 1'b0;
  logic prev_done = 1'b0;

  always #2.5 clk = ~clk;

  pci_init_term_ctl u0 (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .start_addr(start_addr),
    .lt_init(lt_init), .gnt_n(gnt_n), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .wbuf_last(wbuf_last), .pf_bound(pf_bound),
    .frame_n(frame_n), .irdy_n(irdy_n), .done(done), .status(status),
    .resume_req(resume_req), .cur_addr(cur_addr)
  );

  // Data-path indications refer to the phase that the coming edge opens.
  wire xnow = !irdy_n && !trdy_n && !devsel_n;
  assign wbuf_last = (xfers + (xnow ? 1 : 0)) >= cfg_n - 1;
  assign pf_bound  = (xfers + (xnow ? 1 : 0)) >= cfg_b - 1;

  always @(posedge clk) begin
    if (start) begin
      ck <= 0; xfers <= 0; stopped <= 1'b0;
    end else begin
      if (!frame_n || !irdy_n) ck <= ck + 1;
      if (xnow) xfers <= xfers + 1;
      if (!stop_n) stopped <= 1'b1;
    end
  end

  // Target model, driven between edges.
  always @(negedge clk) begin
    logic act, dv;
    act = !frame_n || !irdy_n;
    dv  = act && (ck >= cfg_d);
    devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
    case (cfg_mode)
      T_NORM: begin
        devsel_n = !dv;
        trdy_n   = !(dv && !irdy_n);
      end
      T_RETRY: begin
        devsel_n = !dv;
        stop_n   = !dv;
      end
      T_DISCD: begin
        devsel_n = !dv;
        if (stopped) stop_n = !act;
        else if (dv && !irdy_n) begin
          trdy_n = 1'b0;
          stop_n = !(xfers == cfg_k - 1);
        end
      end
      T_DISCN: begin
        devsel_n = !dv;
        if (xfers >= cfg_k) stop_n = !dv;
        else trdy_n = !(dv && !irdy_n);
      end
      T_TABT: begin
        devsel_n = !(act && ck == cfg_d);
        stop_n   = !(act && ck > cfg_d);
      end
      default: ;
    endcase
    if (frame_n && !irdy_n) last_cycles = last_cycles + 1;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Monitor: pops an expected outcome on every done strobe.
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) chk("R12 done longer than one clock", 32'd1, 32'd0);
      if (done) begin
        if (sb.size() == 0) chk("R12 unexpected done", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " status"}, {29'd0, status}, {29'd0, e.st});
          chk({e.tag, " cur_addr"}, cur_addr, e.ad);
          chk({e.tag, " resume_req"}, {31'd0, resume_req}, {31'd0, e.rs});
          chk({e.tag, " bus idle at done"}, {30'd0, frame_n, irdy_n}, 32'd3);
        end
      end
      prev_done <= done;
    end
  end

  task automatic txn(input string tag, input logic [2:0] k, input logic [31:0] a,
                     input logic [7:0] lt, input logic g, input int n, input int b,
                     input int d, input int mode, input int kk,
                     input logic [2:0] est, input logic [31:0] ead, input logic ers);
    exp_t e;
    e.tag = tag; e.st = est; e.ad = ead; e.rs = ers;
    sb.push_back(e);
    @(negedge clk);
    cfg_n = n; cfg_b = b; cfg_d = d; cfg_mode = mode; cfg_k = kk;
    kind = k; start_addr = a; lt_init = lt; gnt_n = g; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    do @(negedge clk); while (!done);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lc0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 frame_n", {31'd0, frame_n}, 32'd1);
    chk("R1 irdy_n", {31'd0, irdy_n}, 32'd1);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 status", {29'd0, status}, 32'd0);
    chk("R1 resume_req", {31'd0, resume_req}, 32'd0);

    // R2 + R12: single DWORD, one cycle of final-phase shape
    lc0 = last_cycles;
    txn("R2 delayed write", K_DW, 32'h1000, 8'd255, 1'b0, 1, 1, 0, T_NORM, 1, OK, 32'h1004, 1'b0);
    chk("R12 final phase frame high irdy low cycles", last_cycles - lc0, 32'd1);
    txn("R2 non-prefetch read", K_NR, 32'h2000, 8'd255, 1'b0, 1, 1, 0, T_NORM, 1, OK, 32'h2004, 1'b0);
    // R3 / R11: bursts
    txn("R3 posted write 4", K_PW, 32'h3000, 8'd255, 1'b0, 4, 1, 0, T_NORM, 1, OK, 32'h3010, 1'b0);
    txn("R3 posted write 1", K_PW, 32'h3100, 8'd255, 1'b0, 1, 1, 0, T_NORM, 1, OK, 32'h3104, 1'b0);
    txn("R11 posted write 6 granted", K_PW, 32'h3200, 8'd2, 1'b0, 6, 1, 0, T_NORM, 1, OK, 32'h3218, 1'b0);
    // R4
    txn("R4 prefetch boundary 3", K_PR, 32'h4000, 8'd255, 1'b0, 1, 3, 0, T_NORM, 1, OK, 32'h400C, 1'b0);
    // R7 / R9: latency cut
    txn("R9 posted write latency cut", K_PW, 32'h5000, 8'd2, 1'b1, 8, 1, 0, T_NORM, 1, LC, 32'h500C, 1'b1);
    txn("R9 prefetch latency cut", K_PR, 32'h5100, 8'd2, 1'b1, 1, 10, 0, T_NORM, 1, LC, 32'h510C, 1'b0);
    txn("R7 latency cut lt=1", K_PW, 32'h5200, 8'd1, 1'b1, 4, 1, 0, T_NORM, 1, LC, 32'h5208, 1'b1);
    txn("R7 natural end wins tie", K_PW, 32'h5300, 8'd1, 1'b1, 2, 1, 0, T_NORM, 1, OK, 32'h5308, 1'b0);
    // R8
    txn("R8 mwi ignores latency", K_MW, 32'h6000, 8'd0, 1'b1, 5, 1, 0, T_NORM, 1, OK, 32'h6014, 1'b0);
    // R5 / R6
    txn("R5 devsel on fifth edge", K_DW, 32'h7000, 8'd255, 1'b0, 1, 1, 4, T_NORM, 1, OK, 32'h7004, 1'b0);
    txn("R5 no devsel final phase", K_DW, 32'h7100, 8'd255, 1'b0, 1, 1, 0, T_NONE, 1, MA, 32'h7100, 1'b0);
    lc0 = last_cycles;
    txn("R6 no devsel mid burst", K_PW, 32'h7200, 8'd255, 1'b0, 4, 1, 0, T_NONE, 1, MA, 32'h7200, 1'b0);
    chk("R6 frame and irdy released together", last_cycles - lc0, 32'd0);
    // R10
    txn("R10 retry single", K_NR, 32'h8000, 8'd255, 1'b0, 1, 1, 1, T_RETRY, 1, RT, 32'h8000, 1'b0);
    txn("R10 retry burst", K_PW, 32'h8100, 8'd255, 1'b0, 6, 1, 0, T_RETRY, 1, RT, 32'h8100, 1'b0);
    txn("R10 disconnect with data", K_PW, 32'h8200, 8'd255, 1'b0, 6, 1, 0, T_DISCD, 2, DC, 32'h8208, 1'b0);
    txn("R10 disconnect without data", K_PW, 32'h8300, 8'd255, 1'b0, 6, 1, 0, T_DISCN, 1, DC, 32'h8304, 1'b0);
    txn("R10 target abort", K_PW, 32'h8400, 8'd255, 1'b0, 6, 1, 0, T_TABT, 1, TA, 32'h8400, 1'b0);

    repeat (4) @(negedge clk);
    chk("R12 every outcome seen", sb.size(), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule